// File: doc/BRIEF.md
# Trapezoidal Stepper Motion Controller

This block turns a two-coil stepper motor through a requested number of steps, in a chosen direction, along a trapezoidal velocity profile. A move begins slowly, gains one speed level at a time, holds the top level while enough steps remain, and then sheds speed again so that the motor comes to rest gently. The four coil outputs go to external power drivers, one complementary pair for each winding.

Step timing comes from a phase accumulator that adds the current speed level, from 1 to 16, on every clock and issues a step each time it wraps. At the top level a step falls every 16 clocks. The ramp rate is a parameter giving the number of steps spent at each speed level. The controller begins to slow down once the remaining steps are no more than the steps it spent speeding up. A short move therefore turns around before it reaches the top level.

Top module: `trap_stepper_ctrl`

## Requirements
- R1: While `rst` is high the coil outputs read a=1, a_n=0, b=1, b_n=0 (coil index 0), `busy` is 0, and `start` has no effect. After release the coil index is 0.
- R2: A move begins at the first rising edge on which `start` is high while idle with a nonzero `step_count`. `dir_sel` and `step_count` are captured at that edge and `busy` rises. Later changes to `dir_sel`, `step_count` or `start` during the move have no effect.
- R3: A move produces exactly `step_count` coil steps. `busy` falls on the same edge as the final step. A `step_count` of 0 starts nothing.
- R4: An 8-bit accumulator adds the speed level every clock, and a step is issued on overflow. The first step comes exactly 256 clocks after the start edge. At level 16 steps are exactly 16 clocks apart, and no two steps are ever closer than 16 clocks.
- R5: Speed begins at level 1 and rises by one level after every `RAMP_STEPS` steps, up to level 16. With `RAMP_STEPS`=2 the first four step intervals are 256, 256, 128 and 128 clocks.
- R6: Deceleration begins when the remaining steps are no more than the steps taken while accelerating. Speed then falls by one level after every `RAMP_STEPS` steps, and never below 1. A move too short to reach level 16 goes straight from accelerating to decelerating.
- R7: The coil index runs over eight states, coded {a,a_n,b,b_n}: 0=1010, 1=0010, 2=0110, 3=0100, 4=0101, 5=0001, 6=1001, 7=1000. A full step (`half_sel`=0) moves the index by 2 and a half step (`half_sel`=1) by 1, both modulo 8. `dir_sel`=0 counts up and `dir_sel`=1 counts down.
- R8: With `half_sel`=1 each step passes through the single-coil states, so consecutive outputs alternate between two energised coils and one.
- R9: `stop` high at an edge while busy ends the move at that edge: no further steps, `busy` low, coils held. `stop` takes priority over `start`. While idle the coils do not change.
- R10: Both halves of a winding (a with a_n, b with b_n) are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| dir_sel | input | 1 | Direction: 0 counts the coil index up, 1 counts it down |
| half_sel | input | 1 | 0 selects full steps, 1 selects half steps |
| step_count | input | 16 | Number of steps in the next move |
| start | input | 1 | Starts a move when sampled high while idle |
| stop | input | 1 | Aborts the current move |
| coil_a | output | 1 | Winding A, forward drive |
| coil_a_n | output | 1 | Winding A, reverse drive |
| coil_b | output | 1 | Winding B, forward drive |
| coil_b_n | output | 1 | Winding B, reverse drive |
| busy | output | 1 | High while a move is in progress |

## Verification
The bench builds the block with `RAMP_STEPS`=2 and keeps the 8-bit accumulator and the top level of 16. That short ramp lets a 100-step move reach cruise within a few thousand clocks, and it fixes the opening intervals at 256, 256, 128 and 128 clocks so that they can be counted exactly. With the same setting a 10-step move turns around at level 3, so the path that skips cruise and the interval floor of 16 clocks are both covered in one run.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCEL  = 2'd1,
        PH_CRUISE = 2'd2,
        PH_DECEL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic a;
        logic a_n;
        logic b;
        logic b_n;
    } coil_t;

    localparam int unsigned SEQ_IDX_W = 3;

    // Eight-state winding table; even indices energise two coils, odd ones one.
    function automatic coil_t coil_of(input logic [SEQ_IDX_W-1:0] idx);
        coil_t c;
        case (idx)
            3'd0:    c = coil_t'(4'b1010);
            3'd1:    c = coil_t'(4'b0010);
            3'd2:    c = coil_t'(4'b0110);
            3'd3:    c = coil_t'(4'b0100);
            3'd4:    c = coil_t'(4'b0101);
            3'd5:    c = coil_t'(4'b0001);
            3'd6:    c = coil_t'(4'b1001);
            default: c = coil_t'(4'b1000);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stp_rate_gen.sv
module stp_rate_gen #(
    parameter int ACC_W = 8,
    parameter int SPD_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             step
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } rate_st_t;

    rate_st_t   st_q, st_d;
    logic [ACC_W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + {{(ACC_W + 1 - SPD_W){1'b0}}, speed};
        step  = 1'b0;
        if (run) begin
            st_d.acc = sum_d[ACC_W-1:0];
            step     = sum_d[ACC_W];
        end else begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4
    step_gap_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/stp_profile.sv
module stp_profile
    import stp_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SPD_W      = 5,
    parameter int MAX_SPEED  = 16,
    parameter int RAMP_STEPS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             step,
    output logic             busy,
    output logic             dir,
    output logic [SPD_W-1:0] speed
);

    localparam int RAMP_W = $clog2(RAMP_STEPS) + 1;
    localparam logic [SPD_W-1:0]  SPD_ONE   = SPD_W'(1);
    localparam logic [SPD_W-1:0]  SPD_TOP   = SPD_W'(MAX_SPEED);
    localparam logic [RAMP_W-1:0] RAMP_LAST = RAMP_W'(RAMP_STEPS - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  ramp_up;
        logic [RAMP_W-1:0] ramp_cnt;
        logic [SPD_W-1:0]  speed;
        logic              dir;
    } prof_st_t;

    prof_st_t st_q, st_d;
    logic [CNT_W-1:0] remain_d;
    logic [CNT_W-1:0] ramp_up_d;
    logic             ramp_due_d;

    always_comb begin
        st_d       = st_q;
        remain_d   = st_q.remain - CNT_ONE;
        ramp_up_d  = st_q.ramp_up + CNT_ONE;
        ramp_due_d = (st_q.ramp_cnt == RAMP_LAST);
        if (st_q.phase == PH_IDLE) begin
            if (start && !stop && (count_in != '0)) begin
                st_d.phase    = PH_ACCEL;
                st_d.remain   = count_in;
                st_d.ramp_up  = '0;
                st_d.ramp_cnt = '0;
                st_d.speed    = SPD_ONE;
                st_d.dir      = dir_in;
            end
        end else if (stop) begin
            st_d.phase = PH_IDLE;
        end else if (step) begin
            st_d.remain = remain_d;
            if (remain_d == '0) begin
                st_d.phase = PH_IDLE;
            end else begin
                case (st_q.phase)
                    PH_ACCEL: begin
                        st_d.ramp_up = ramp_up_d;
                        if (remain_d <= ramp_up_d) begin
                            st_d.phase    = PH_DECEL;
                            st_d.ramp_cnt = '0;
                        end else if (ramp_due_d) begin
                            st_d.ramp_cnt = '0;
                            st_d.speed    = st_q.speed + SPD_ONE;
                            if (st_q.speed + SPD_ONE == SPD_TOP) st_d.phase = PH_CRUISE;
                        end else begin
                            st_d.ramp_cnt = st_q.ramp_cnt + RAMP_W'(1);
                        end
                    end
                    PH_CRUISE: begin
                        if (remain_d <= st_q.ramp_up) begin
                            st_d.phase    = PH_DECEL;
                            st_d.ramp_cnt = '0;
                        end
                    end
                    default: begin
                        if (ramp_due_d) begin
                            st_d.ramp_cnt = '0;
                            if (st_q.speed > SPD_ONE) st_d.speed = st_q.speed - SPD_ONE;
                        end else begin
                            st_d.ramp_cnt = st_q.ramp_cnt + RAMP_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q          <= '0;
            st_q.phase    <= PH_IDLE;
            st_q.speed    <= SPD_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.phase != PH_IDLE);
    assign dir   = st_q.dir;
    assign speed = st_q.speed;

    // R9
    stop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && stop) |=> !busy);

    // R5
    speed_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (speed >= SPD_ONE && speed <= SPD_TOP));

    // R6
    speed_slew_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && speed != $past(speed)) |->
        (speed == $past(speed) + SPD_ONE || speed == $past(speed) - SPD_ONE));

    // R3
    remain_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && step && !stop) |=> (st_q.remain == $past(st_q.remain) - CNT_ONE));

endmodule

// File: rtl/stp_coil_seq.sv
module stp_coil_seq
    import stp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  dir,
    input  logic  half,
    output coil_t coils
);

    typedef struct packed {
        logic [SEQ_IDX_W-1:0] idx;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic [SEQ_IDX_W-1:0] delta_d;

    always_comb begin
        st_d    = st_q;
        delta_d = half ? SEQ_IDX_W'(1) : SEQ_IDX_W'(2);
        if (step) begin
            st_d.idx = dir ? (st_q.idx - delta_d) : (st_q.idx + delta_d);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign coils = coil_of(st_q.idx);

    // R10
    coil_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(coils.a && coils.a_n) && !(coils.b && coils.b_n));

endmodule

// File: rtl/trap_stepper_ctrl.sv
module trap_stepper_ctrl #(
    parameter int CNT_W      = 16,
    parameter int ACC_W      = 8,
    parameter int MAX_SPEED  = 16,
    parameter int RAMP_STEPS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_sel,
    input  logic             half_sel,
    input  logic [CNT_W-1:0] step_count,
    input  logic             start,
    input  logic             stop,
    output logic             coil_a,
    output logic             coil_a_n,
    output logic             coil_b,
    output logic             coil_b_n,
    output logic             busy
);

    import stp_pkg::*;

    localparam int SPD_W = $clog2(MAX_SPEED + 1);

    logic             busy_w;
    logic             dir_w;
    logic             step_w;
    logic [SPD_W-1:0] speed_w;
    coil_t            coils_w;

    stp_profile #(
        .CNT_W      (CNT_W),
        .SPD_W      (SPD_W),
        .MAX_SPEED  (MAX_SPEED),
        .RAMP_STEPS (RAMP_STEPS)
    ) u_profile (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .dir_in   (dir_sel),
        .count_in (step_count),
        .step     (step_w),
        .busy     (busy_w),
        .dir      (dir_w),
        .speed    (speed_w)
    );

    stp_rate_gen #(
        .ACC_W (ACC_W),
        .SPD_W (SPD_W)
    ) u_rate (
        .clk   (clk),
        .rst   (rst),
        .run   (busy_w && !stop),
        .speed (speed_w),
        .step  (step_w)
    );

    stp_coil_seq u_coils (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .dir   (dir_w),
        .half  (half_sel),
        .coils (coils_w)
    );

    assign coil_a   = coils_w.a;
    assign coil_a_n = coils_w.a_n;
    assign coil_b   = coils_w.b;
    assign coil_b_n = coils_w.b_n;
    assign busy     = busy_w;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_w |=> $stable(coils_w));

    // R2
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_w && start && !stop && step_count != '0) |=> busy_w);

endmodule

// File: tb/trap_stepper_ctrl_test.sv
`timescale 1ns/1ps
module trap_stepper_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_sel = 1'b0;
    logic        half_sel = 1'b0;
    logic [15:0] step_count = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        coil_a, coil_a_n, coil_b, coil_b_n, busy;

    int checks = 0;
    int fails = 0;
    int cycle = 0;
    int pos = 0;

    int   chg_n = 0;
    int   chg_t [0:1023];
    logic [3:0] chg_c [0:1023];
    logic chg_busy [0:1023];
    logic [3:0] prev_code = 4'b1010;

    trap_stepper_ctrl #(.RAMP_STEPS(2)) uut (
        .clk(clk), .rst(rst), .dir_sel(dir_sel), .half_sel(half_sel),
        .step_count(step_count), .start(start), .stop(stop),
        .coil_a(coil_a), .coil_a_n(coil_a_n), .coil_b(coil_b), .coil_b_n(coil_b_n),
        .busy(busy)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cycle <= cycle + 1;

    always @(negedge clk) begin
        if (rst) begin
            prev_code <= 4'b1010;
        end else begin
            if ({coil_a, coil_a_n, coil_b, coil_b_n} != prev_code && chg_n < 1024) begin
                chg_t[chg_n]    <= cycle;
                chg_c[chg_n]    <= {coil_a, coil_a_n, coil_b, coil_b_n};
                chg_busy[chg_n] <= busy;
                chg_n           <= chg_n + 1;
            end
            prev_code <= {coil_a, coil_a_n, coil_b, coil_b_n};
        end
    end

    function automatic logic [3:0] exp_code(input int idx);
        case (((idx % 8) + 8) % 8)
            0: return 4'b1010;
            1: return 4'b0010;
            2: return 4'b0110;
            3: return 4'b0100;
            4: return 4'b0101;
            5: return 4'b0001;
            6: return 4'b1001;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        start = 1'b1;
        step_count = 16'd5;
        repeat (4) @(negedge clk);
        chk({coil_a, coil_a_n, coil_b, coil_b_n} == 4'b1010, "R1", "coils in reset",
            {coil_a, coil_a_n, coil_b, coil_b_n}, 4'b1010);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        start = 1'b0;
        rst = 1'b0;
        pos = 0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after release", busy, 0);
    endtask

    // Pulses start for one edge; returns the chg_n base and the start cycle.
    task automatic launch(input logic d, input logic h, input int n,
                          output int base, output int t0);
        @(negedge clk);
        dir_sel = d; half_sel = h; step_count = 16'(n); start = 1'b1;
        base = chg_n;
        @(negedge clk);
        start = 1'b0;
        t0 = cycle;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_seq(input int base, input int cnt, input int dir,
                             input int delta, input string req);
        for (int k = 0; k < cnt; k++) begin
            int idx;
            idx = pos + (dir ? -(k + 1) * delta : (k + 1) * delta);
            chk(chg_c[base + k] == exp_code(idx), req, "coil code",
                chg_c[base + k], exp_code(idx));
        end
        pos = pos + (dir ? -cnt * delta : cnt * delta);
        pos = ((pos % 8) + 8) % 8;
    endtask

    task automatic test_reset_state;
        do_reset();
        chk({coil_a, coil_a_n, coil_b, coil_b_n} == 4'b1010, "R1", "index 0 after release",
            {coil_a, coil_a_n, coil_b, coil_b_n}, 4'b1010);
    endtask

    task automatic test_ramp_forward;
        int base, t0;
        launch(1'b0, 1'b0, 12, base, t0);
        chk(busy == 1'b1, "R2", "busy after start edge", busy, 1);
        // R2: inputs changed during the move must not matter
        dir_sel = 1'b1; step_count = 16'd3;
        repeat (300) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_idle(20000);
        chk(chg_n - base == 12, "R3", "full move step count", chg_n - base, 12);
        chk(chg_t[base] - t0 == 256, "R4", "first step delay", chg_t[base] - t0, 256);
        chk(chg_t[base + 1] - chg_t[base] == 256, "R5", "interval 2", chg_t[base + 1] - chg_t[base], 256);
        chk(chg_t[base + 2] - chg_t[base + 1] == 128, "R5", "interval 3", chg_t[base + 2] - chg_t[base + 1], 128);
        chk(chg_t[base + 3] - chg_t[base + 2] == 128, "R5", "interval 4", chg_t[base + 3] - chg_t[base + 2], 128);
        chk(chg_busy[base + 10] == 1'b1, "R3", "busy before last step", chg_busy[base + 10], 1);
        chk(chg_busy[base + 11] == 1'b0, "R3", "busy falls with last step", chg_busy[base + 11], 0);
        check_seq(base, 12, 0, 2, "R7");
    endtask

    task automatic test_long_reverse;
        int base, t0, n16, mn, last;
        launch(1'b1, 1'b0, 100, base, t0);
        wait_idle(20000);
        chk(chg_n - base == 100, "R3", "long move step count", chg_n - base, 100);
        n16 = 0; mn = 100000;
        for (int k = 1; k < 100; k++) begin
            int iv;
            iv = chg_t[base + k] - chg_t[base + k - 1];
            if (iv == 16) n16++;
            if (iv < mn) mn = iv;
        end
        chk(n16 >= 30, "R4", "cruise intervals of 16", n16, 30);
        chk(mn >= 16, "R4", "minimum interval", mn, 16);
        last = chg_t[base + 99] - chg_t[base + 98];
        chk(last > 16, "R6", "final interval slowed", last, 17);
        check_seq(base, 100, 1, 2, "R7");
    endtask

    task automatic test_short_half;
        int base, t0, mn;
        launch(1'b0, 1'b1, 10, base, t0);
        wait_idle(20000);
        chk(chg_n - base == 10, "R3", "short move step count", chg_n - base, 10);
        mn = 100000;
        for (int k = 1; k < 10; k++) begin
            int iv;
            iv = chg_t[base + k] - chg_t[base + k - 1];
            if (iv < mn) mn = iv;
        end
        chk(mn > 16, "R6", "short move never cruises", mn, 17);
        check_seq(base, 10, 0, 1, "R8");
    endtask

    task automatic test_zero;
        int base, t0;
        launch(1'b0, 1'b0, 0, base, t0);
        chk(busy == 1'b0, "R3", "zero count stays idle", busy, 0);
        repeat (300) @(negedge clk);
        chk(chg_n == base, "R3", "zero count no steps", chg_n - base, 0);
    endtask

    task automatic test_stop;
        int base, t0, got;
        launch(1'b0, 1'b0, 50, base, t0);
        for (int i = 0; i < 5000 && chg_n - base < 3; i++) @(negedge clk);
        stop = 1'b1; start = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after stop", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R9", "stop beats start while idle", busy, 0);
        stop = 1'b0; start = 1'b0;
        got = chg_n - base;
        repeat (600) @(negedge clk);
        chk(chg_n - base == got, "R9", "no steps after stop", chg_n - base, got);
        chk(got == 3, "R9", "steps before abort", got, 3);
        check_seq(base, got, 0, 2, "R9");
    endtask

    task automatic test_reset_mid;
        int base, t0;
        launch(1'b0, 1'b1, 40, base, t0);
        for (int i = 0; i < 5000 && chg_n - base < 2; i++) @(negedge clk);
        rst = 1'b1; start = 1'b1;
        @(negedge clk);
        chk({coil_a, coil_a_n, coil_b, coil_b_n} == 4'b1010, "R1", "coils forced by reset",
            {coil_a, coil_a_n, coil_b, coil_b_n}, 4'b1010);
        repeat (300) @(negedge clk);
        chk(busy == 1'b0, "R1", "start ignored in reset", busy, 0);
        start = 1'b0; rst = 1'b0; pos = 0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "idle after reset", busy, 0);
    endtask

    task automatic test_exclusive;
        // R10: sampled over each recorded coil code
        int bad;
        bad = 0;
        for (int k = 0; k < chg_n; k++)
            if ((chg_c[k][3] && chg_c[k][2]) || (chg_c[k][1] && chg_c[k][0])) bad++;
        chk(bad == 0, "R10", "winding halves both high", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        test_reset_state();
        test_ramp_forward();
        test_long_reverse();
        test_short_half();
        test_zero();
        test_stop();
        test_reset_mid();
        test_exclusive();
        report();
    end

endmodule